// File: doc/BRIEF.md
# IQ Transmit Input Assembler

This block sits at the input of a transmit path. A baseband device sends I and Q samples one after another over a single 12-bit word bus, together with a bus clock and a qualifier line. The block captures each word and decides which channel it belongs to. It rebuilds complete I/Q pairs, converts the sample format to two's complement, and hands the pairs to the DAC-side clock domain through an eight-entry asynchronous FIFO.

In single-rate mode, a word is captured on the rising bus clock edge. The qualifier level says whether the word is I or Q, and a configuration bit says which channel opens a pair. A pair is only written once both halves are present. In double-rate mode, words are captured on both bus clock edges and the edge tells the channels apart. The DAC side takes one pair every 1, 2, 4 or 8 DAC clock cycles, which is the clock after division by the interpolation ratio. Sticky flags report pairs lost to a full FIFO and read slots that found it empty.

Top module: `tx_iq_assembler`

## Requirements
- R1: In single-rate mode (cfgDdr=0), txData and txQual are sampled together on the rising edge of busClk.
- R2: In single-rate mode, a word is I when txQual equals cfgQualHighIsI and Q otherwise.
- R3: With cfgFirstIsQ=0, an I word opens a pair and the following Q word completes it; with cfgFirstIsQ=1 the roles swap. Each completed pair is delivered exactly once, with the I word on outI and the Q word on outQ.
- R4: A word that opens a pair while one is already open replaces the held word. A closing word with no open pair is dropped. A half pair is never written.
- R5: The read side makes one read attempt every 2^cfgInterp dacClk cycles. A successful attempt gives a one-cycle outValid pulse, with outI/outQ held valid in that cycle.
- R6: In double-rate mode (cfgDdr=1), the word on a rising busClk edge is the opening word and the word on the following falling edge is the closing word (I opens when cfgFirstIsQ=0). txQual is ignored, and one pair is formed per busClk cycle.
- R7: With cfgTwosComp=1 the words pass through unchanged. With cfgTwosComp=0 the input is offset binary, and each output equals the input minus 2048 modulo 4096.
- R8: The FIFO holds 8 pairs and keeps their order. A pair that completes while the FIFO is full is dropped and sets overflowFlag, which stays set until reset.
- R9: A read attempt that finds the FIFO empty sets underflowFlag (sticky until reset), but only after at least one pair has been read since reset.
- R10: During and right after reset, outValid, outI, outQ, overflowFlag and underflowFlag are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| busClk | input | 1 | Transmit word bus clock |
| busRstN | input | 1 | Active-low asynchronous reset, bus domain |
| txData | input | 12 | Interleaved I/Q word |
| txQual | input | 1 | Channel qualifier for single-rate mode |
| cfgDdr | input | 1 | 1: capture on both edges, edge selects channel |
| cfgFirstIsQ | input | 1 | 1: Q word opens a pair |
| cfgQualHighIsI | input | 1 | 1: qualifier high marks I |
| cfgTwosComp | input | 1 | 1: input is two's complement, 0: offset binary |
| dacClk | input | 1 | DAC clock, read domain |
| dacRstN | input | 1 | Active-low asynchronous reset, read domain |
| cfgInterp | input | 2 | log2 of the interpolation ratio (0..3) |
| outValid | output | 1 | One-cycle pulse per delivered pair |
| outI | output | 12 | I sample, two's complement |
| outQ | output | 12 | Q sample, two's complement |
| overflowFlag | output | 1 | Sticky: a pair was dropped at a full FIFO |
| underflowFlag | output | 1 | Sticky: a read slot found the FIFO empty |

## Verification
A single-rate pair is written to the FIFO on the busClk rising edge after its closing word is captured. It then needs two dacClk edges to pass the pointer synchronizer, waits for the next read slot (up to 2^cfgInterp dacClk cycles), and shows on outI/outQ one dacClk edge after that slot. The bench does not predict the exact edge. It drives each stimulus burst, waits a fixed settling time far longer than this worst case, and then compares the whole ordered list of pairs collected on dacClk falling edges against values computed from the requirement formulas. Read pacing is checked by timestamping outValid while the FIFO holds a backlog: consecutive pulses must be exactly 2^cfgInterp dacClk periods apart.

// File: rtl/tx_asm_pkg.sv
`timescale 1ns/1ps
package tx_asm_pkg;
  // Per-word actions the pairing control hands to the datapath and FIFO
  typedef struct packed {
    logic loadFirst;  // hold the captured word as the opening half
    logic pushPair;   // a full pair is ready for the FIFO this edge
  } asm_strobe_t;
endpackage

// File: rtl/tx_asm_ctrl.sv
`timescale 1ns/1ps
module tx_asm_ctrl
  import tx_asm_pkg::*;
(
  input  logic        busClk,
  input  logic        busRstN,
  input  logic        capValid,
  input  logic        capQual,
  input  logic        cfgDdr,
  input  logic        cfgFirstIsQ,
  input  logic        cfgQualHighIsI,
  output asm_strobe_t strobe
);
  logic haveFirst;
  logic isI;
  logic isOpening;

  assign isI       = (capQual == cfgQualHighIsI);
  assign isOpening = isI ^ cfgFirstIsQ;

  always_comb begin
    strobe = '0;
    if (capValid) begin
      if (cfgDdr) begin
        strobe.pushPair = 1'b1;
      end else if (isOpening) begin
        strobe.loadFirst = 1'b1;
      end else if (haveFirst) begin
        strobe.pushPair = 1'b1;
      end
    end
  end

  always_ff @(posedge busClk or negedge busRstN) begin
    if (!busRstN) begin
      haveFirst <= 1'b0;
    end else if (capValid && !cfgDdr) begin
      haveFirst <= isOpening;
    end
  end

  // R3: each captured word takes at most one action
  a_r3_one_action: assert property (@(posedge busClk) disable iff (!busRstN)
    $onehot0({strobe.loadFirst, strobe.pushPair}));

  // R4: a completed single-rate pair consumes its opening word
  a_r4_no_back_to_back_sdr: assert property (@(posedge busClk) disable iff (!busRstN)
    (!cfgDdr && strobe.pushPair) |=> (cfgDdr || !strobe.pushPair));
endmodule

// File: rtl/tx_asm_datapath.sv
`timescale 1ns/1ps
module tx_asm_datapath
  import tx_asm_pkg::*;
#(
  parameter int WORD_W = 12
) (
  input  logic                busClk,
  input  logic                busRstN,
  input  logic [WORD_W-1:0]   txData,
  input  logic                txQual,
  input  logic                cfgDdr,
  input  logic                cfgFirstIsQ,
  input  logic                cfgTwosComp,
  input  asm_strobe_t         strobe,
  output logic                capQual,
  output logic                capValid,
  output logic [2*WORD_W-1:0] pairWord
);
  logic [WORD_W-1:0] capData;
  logic [WORD_W-1:0] firstReg;
  logic [WORD_W-1:0] fallReg;
  logic [WORD_W-1:0] openWord;
  logic [WORD_W-1:0] closeWord;
  logic [WORD_W-1:0] iRaw;
  logic [WORD_W-1:0] qRaw;

  function automatic logic [WORD_W-1:0] toTwos(input logic [WORD_W-1:0] w, input logic isTwos);
    logic [WORD_W-1:0] r;
    r = w;
    r[WORD_W-1] = w[WORD_W-1] ^ ~isTwos;
    return r;
  endfunction

  always_ff @(posedge busClk or negedge busRstN) begin
    if (!busRstN) begin
      capData  <= '0;
      capQual  <= 1'b0;
      capValid <= 1'b0;
      firstReg <= '0;
    end else begin
      capData  <= txData;
      capQual  <= txQual;
      capValid <= 1'b1;
      if (strobe.loadFirst) firstReg <= capData;
    end
  end

  // Falling-edge capture, used only in double-rate mode
  always_ff @(negedge busClk or negedge busRstN) begin
    if (!busRstN) fallReg <= '0;
    else          fallReg <= txData;
  end

  assign openWord  = cfgDdr ? capData : firstReg;
  assign closeWord = cfgDdr ? fallReg : capData;
  assign iRaw      = cfgFirstIsQ ? closeWord : openWord;
  assign qRaw      = cfgFirstIsQ ? openWord  : closeWord;
  assign pairWord  = {toTwos(iRaw, cfgTwosComp), toTwos(qRaw, cfgTwosComp)};

  // R1: capture is marked valid from the first rising edge after reset onward
  a_r1_capture_valid_holds: assert property (@(posedge busClk) disable iff (!busRstN)
    capValid |=> capValid);
endmodule

// File: rtl/tx_asm_fifo.sv
`timescale 1ns/1ps
module tx_asm_fifo #(
  parameter int DATA_W = 24,
  parameter int ADDR_W = 3
) (
  input  logic              wClk,
  input  logic              wRstN,
  input  logic              wEn,
  input  logic [DATA_W-1:0] wData,
  output logic              overflowFlag,
  input  logic              rClk,
  input  logic              rRstN,
  input  logic              rEn,
  output logic [DATA_W-1:0] rData,
  output logic              rValid,
  output logic              underflowFlag
);
  localparam int DEPTH = 1 << ADDR_W;
  localparam int PTR_W = ADDR_W + 1;

  function automatic logic [PTR_W-1:0] bin2gray(input logic [PTR_W-1:0] b);
    return b ^ (b >> 1);
  endfunction

  function automatic logic [PTR_W-1:0] gray2bin(input logic [PTR_W-1:0] g);
    logic [PTR_W-1:0] b;
    b[PTR_W-1] = g[PTR_W-1];
    for (int i = PTR_W - 2; i >= 0; i--) b[i] = b[i+1] ^ g[i];
    return b;
  endfunction

  logic [DATA_W-1:0] mem [DEPTH];

  // Write domain
  logic [PTR_W-1:0] wBin, wBinNext, wGray;
  logic [PTR_W-1:0] rGraySyncA, rGraySyncB;
  logic             full, wAccept;

  assign wBinNext = wBin + PTR_W'(1);
  assign full     = (wGray == {~rGraySyncB[PTR_W-1:PTR_W-2], rGraySyncB[PTR_W-3:0]});
  assign wAccept  = wEn && !full;

  // Read domain
  logic [PTR_W-1:0] rBin, rBinNext, rGray;
  logic [PTR_W-1:0] wGraySyncA, wGraySyncB;
  logic             empty, started;

  assign rBinNext = rBin + PTR_W'(1);
  assign empty    = (rGray == wGraySyncB);

  always_ff @(posedge wClk or negedge wRstN) begin
    if (!wRstN) begin
      wBin         <= '0;
      wGray        <= '0;
      rGraySyncA   <= '0;
      rGraySyncB   <= '0;
      overflowFlag <= 1'b0;
    end else begin
      rGraySyncA <= rGray;
      rGraySyncB <= rGraySyncA;
      if (wAccept) begin
        wBin  <= wBinNext;
        wGray <= bin2gray(wBinNext);
      end
      if (wEn && full) overflowFlag <= 1'b1;
    end
  end

  always_ff @(posedge wClk) begin
    if (wAccept) mem[wBin[ADDR_W-1:0]] <= wData;
  end

  always_ff @(posedge rClk or negedge rRstN) begin
    if (!rRstN) begin
      rBin          <= '0;
      rGray         <= '0;
      wGraySyncA    <= '0;
      wGraySyncB    <= '0;
      rData         <= '0;
      rValid        <= 1'b0;
      started       <= 1'b0;
      underflowFlag <= 1'b0;
    end else begin
      wGraySyncA <= wGray;
      wGraySyncB <= wGraySyncA;
      rValid     <= 1'b0;
      if (rEn && !empty) begin
        rData   <= mem[rBin[ADDR_W-1:0]];
        rValid  <= 1'b1;
        rBin    <= rBinNext;
        rGray   <= bin2gray(rBinNext);
        started <= 1'b1;
      end else if (rEn && started) begin
        underflowFlag <= 1'b1;
      end
    end
  end

  // R8: write-side occupancy never exceeds the FIFO depth
  a_r8_occupancy_bound: assert property (@(posedge wClk) disable iff (!wRstN)
    (wBin - gray2bin(rGraySyncB)) <= PTR_W'(DEPTH));

  // R8: overflow is sticky
  a_r8_overflow_sticky: assert property (@(posedge wClk) disable iff (!wRstN)
    overflowFlag |=> overflowFlag);

  // R9: underflow is sticky
  a_r9_underflow_sticky: assert property (@(posedge rClk) disable iff (!rRstN)
    underflowFlag |=> underflowFlag);

  // R5: output data only appears after a read slot
  a_r5_valid_follows_slot: assert property (@(posedge rClk) disable iff (!rRstN)
    rValid |-> $past(rEn));
endmodule

// File: rtl/tx_asm_rdpace.sv
`timescale 1ns/1ps
module tx_asm_rdpace #(
  parameter int INTERP_W = 2
) (
  input  logic                dacClk,
  input  logic                dacRstN,
  input  logic [INTERP_W-1:0] cfgInterp,
  output logic                readSlot
);
  localparam int CNT_W = (1 << INTERP_W) - 1;

  logic [CNT_W-1:0] slotCnt;
  logic [CNT_W-1:0] slotLast;

  assign slotLast = (CNT_W'(1) << cfgInterp) - CNT_W'(1);
  assign readSlot = (slotCnt == slotLast);

  always_ff @(posedge dacClk or negedge dacRstN) begin
    if (!dacRstN)      slotCnt <= '0;
    else if (readSlot) slotCnt <= '0;
    else               slotCnt <= slotCnt + CNT_W'(1);
  end

  // R5: with a ratio above 1, read slots never fall on adjacent cycles
  a_r5_slot_spacing: assert property (@(posedge dacClk) disable iff (!dacRstN)
    (cfgInterp != '0 && $stable(cfgInterp) && readSlot) |=> !readSlot);
endmodule

// File: rtl/tx_iq_assembler.sv
`timescale 1ns/1ps
module tx_iq_assembler
  import tx_asm_pkg::*;
#(
  parameter int WORD_W   = 12,
  parameter int FIFO_AW  = 3,
  parameter int INTERP_W = 2
) (
  input  logic                busClk,
  input  logic                busRstN,
  input  logic [WORD_W-1:0]   txData,
  input  logic                txQual,
  input  logic                cfgDdr,
  input  logic                cfgFirstIsQ,
  input  logic                cfgQualHighIsI,
  input  logic                cfgTwosComp,
  input  logic                dacClk,
  input  logic                dacRstN,
  input  logic [INTERP_W-1:0] cfgInterp,
  output logic                outValid,
  output logic [WORD_W-1:0]   outI,
  output logic [WORD_W-1:0]   outQ,
  output logic                overflowFlag,
  output logic                underflowFlag
);
  localparam int PAIR_W = 2 * WORD_W;

  asm_strobe_t       strobe;
  logic              capQual;
  logic              capValid;
  logic [PAIR_W-1:0] pairWord;
  logic [PAIR_W-1:0] readWord;
  logic              readSlot;

  tx_asm_ctrl u_ctrl (
    .busClk         (busClk),
    .busRstN        (busRstN),
    .capValid       (capValid),
    .capQual        (capQual),
    .cfgDdr         (cfgDdr),
    .cfgFirstIsQ    (cfgFirstIsQ),
    .cfgQualHighIsI (cfgQualHighIsI),
    .strobe         (strobe)
  );

  tx_asm_datapath #(.WORD_W(WORD_W)) u_dp (
    .busClk      (busClk),
    .busRstN     (busRstN),
    .txData      (txData),
    .txQual      (txQual),
    .cfgDdr      (cfgDdr),
    .cfgFirstIsQ (cfgFirstIsQ),
    .cfgTwosComp (cfgTwosComp),
    .strobe      (strobe),
    .capQual     (capQual),
    .capValid    (capValid),
    .pairWord    (pairWord)
  );

  tx_asm_rdpace #(.INTERP_W(INTERP_W)) u_pace (
    .dacClk    (dacClk),
    .dacRstN   (dacRstN),
    .cfgInterp (cfgInterp),
    .readSlot  (readSlot)
  );

  tx_asm_fifo #(.DATA_W(PAIR_W), .ADDR_W(FIFO_AW)) u_fifo (
    .wClk          (busClk),
    .wRstN         (busRstN),
    .wEn           (strobe.pushPair),
    .wData         (pairWord),
    .overflowFlag  (overflowFlag),
    .rClk          (dacClk),
    .rRstN         (dacRstN),
    .rEn           (readSlot),
    .rData         (readWord),
    .rValid        (outValid),
    .underflowFlag (underflowFlag)
  );

  assign outI = readWord[PAIR_W-1:WORD_W];
  assign outQ = readWord[WORD_W-1:0];
endmodule

// File: tb/tb_tx_iq_assembler.sv
`timescale 1ns/1ps
module tb_tx_iq_assembler;
  logic        busClk = 1'b0;
  logic        dacClk = 1'b0;
  logic        rstN   = 1'b0;
  logic [11:0] txData = '0;
  logic        txQual = 1'b0;
  logic        cfgDdr = 1'b0, cfgFirstIsQ = 1'b0, cfgQualHighIsI = 1'b1, cfgTwosComp = 1'b1;
  logic [1:0]  cfgInterp = 2'd0;
  logic        outValid, overflowFlag, underflowFlag;
  logic [11:0] outI, outQ;

  always #2.5 busClk = ~busClk;  // 200 MHz
  always #2   dacClk = ~dacClk;  // 250 MHz read side

  tx_iq_assembler dut (
    .busClk(busClk), .busRstN(rstN), .txData(txData), .txQual(txQual),
    .cfgDdr(cfgDdr), .cfgFirstIsQ(cfgFirstIsQ), .cfgQualHighIsI(cfgQualHighIsI),
    .cfgTwosComp(cfgTwosComp), .dacClk(dacClk), .dacRstN(rstN), .cfgInterp(cfgInterp),
    .outValid(outValid), .outI(outI), .outQ(outQ),
    .overflowFlag(overflowFlag), .underflowFlag(underflowFlag)
  );

  int      errors = 0;
  int      checks = 0;
  int      nOut = 0;
  int      outsI [256];
  int      outsQ [256];
  realtime outT  [256];
  int      expI  [32];
  int      expQ  [32];
  int      nExp = 0;

  always @(negedge dacClk) begin
    if (rstN && outValid && nOut < 256) begin
      outsI[nOut] = int'(outI);
      outsQ[nOut] = int'(outQ);
      outT[nOut]  = $realtime;
      nOut = nOut + 1;
    end
  end

  task automatic chk(input bit ok, input string what, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual=%0d expected=%0d", what, act, exp);
    end
  endtask

  function automatic int fmt(input int raw, input bit tc);
    return tc ? raw : (raw + 2048) % 4096;
  endfunction

  task automatic doReset();
    rstN = 1'b0;
    repeat (3) @(negedge busClk);
    nOut = 0;
    nExp = 0;
    rstN = 1'b1;
    repeat (2) @(negedge busClk);
  endtask

  task automatic sendSdr(input int word, input bit qual);
    @(negedge busClk);
    txData = word[11:0];
    txQual = qual;
  endtask

  task automatic compareFrom(input int start, input string tag);
    for (int k = 0; k < nExp; k++) begin
      chk(outsI[start+k] == expI[k], {tag, " I word"}, outsI[start+k], expI[k]);
      chk(outsQ[start+k] == expQ[k], {tag, " Q word"}, outsQ[start+k], expQ[k]);
    end
  endtask

  task automatic runSdr(input bit fq, input bit qh, input bit tc, input int idx);
    int rawI, rawQ;
    bit closeQual;
    cfgDdr = 1'b0; cfgFirstIsQ = fq; cfgQualHighIsI = qh; cfgTwosComp = tc; cfgInterp = 2'd0;
    closeQual = fq ? qh : ~qh;     // idle words are closing words, so they are dropped
    txQual = closeQual; txData = '0;
    doReset();
    for (int k = 0; k < 6; k++) begin
      rawI = (256 + k * 81 + idx * 144) % 4096;
      rawQ = (1792 + k * 35 + idx * 7) % 4096;
      expI[k] = fmt(rawI, tc);
      expQ[k] = fmt(rawQ, tc);
      if (fq) begin
        sendSdr(rawQ, ~qh);
        sendSdr(rawI, qh);
      end else begin
        sendSdr(rawI, qh);
        sendSdr(rawQ, ~qh);
      end
    end
    nExp = 6;
    @(negedge busClk); txQual = closeQual; txData = '0;
    repeat (30) @(negedge busClk);
    chk(nOut == nExp, "R3 single-rate pair count", nOut, nExp);
    if (nOut >= nExp) compareFrom(0, "R1,R2,R3,R7 single-rate pair");
  endtask

  task automatic runDdr(input bit fq, input bit tc);
    int rawA, rawB, start;
    cfgDdr = 1'b1; cfgFirstIsQ = fq; cfgQualHighIsI = 1'b1; cfgTwosComp = tc; cfgInterp = 2'd0;
    txData = '0; txQual = 1'b0;
    doReset();
    for (int k = 0; k < 6; k++) begin
      rawA = 256 + k * 81;         // rising-edge word
      rawB = 1792 + k * 35;        // falling-edge word
      expI[k] = fmt(fq ? rawB : rawA, tc);
      expQ[k] = fmt(fq ? rawA : rawB, tc);
      @(negedge busClk); #1; txData = rawA[11:0]; txQual = k[0];
      @(posedge busClk); #1; txData = rawB[11:0]; txQual = ~k[1];
    end
    nExp = 6;
    @(negedge busClk); #1; txData = '0;
    repeat (20) @(negedge busClk);
    start = -1;
    for (int j = 0; j < nOut; j++)
      if (start < 0 && outsI[j] == expI[0] && outsQ[j] == expQ[0]) start = j;
    chk(start >= 0 && start + nExp <= nOut, "R6 double-rate sequence found", start, 0);
    if (start >= 0 && start + nExp <= nOut) compareFrom(start, "R6,R7 double-rate pair");
    chk(overflowFlag == 1'b0, "R8 no overflow when read is fast", int'(overflowFlag), 0);
  endtask

  initial begin
    #(100000 * 5);
    errors++;
    checks++;
    $display("FAIL watchdog: actual=%0d expected=%0d", 1, 0);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    int idx;
    // R10 and R9: reset state and no underflow before any pair was read
    doReset();
    chk(outValid == 1'b0, "R10 outValid after reset", int'(outValid), 0);
    chk(outI == '0 && outQ == '0, "R10 outputs zero after reset", int'(outI), 0);
    chk(overflowFlag == 1'b0, "R10 overflow clear after reset", int'(overflowFlag), 0);
    repeat (20) @(negedge busClk);
    chk(underflowFlag == 1'b0, "R9 no underflow before first read", int'(underflowFlag), 0);
    chk(nOut == 0, "R4 idle closing words dropped", nOut, 0);

    // Single-rate sweep over pairing order, qualifier polarity and format
    idx = 0;
    for (int fq = 0; fq < 2; fq++)
      for (int qh = 0; qh < 2; qh++)
        for (int tc = 0; tc < 2; tc++) begin
          runSdr(fq[0], qh[0], tc[0], idx);
          chk(underflowFlag == 1'b1, "R9 underflow after drain", int'(underflowFlag), 1);
          idx++;
        end

    // Double-rate sweep
    for (int fq = 0; fq < 2; fq++)
      for (int tc = 0; tc < 2; tc++)
        runDdr(fq[0], tc[0]);

    // R4 restart: stray closing word, repeated opening word
    cfgDdr = 1'b0; cfgFirstIsQ = 1'b0; cfgQualHighIsI = 1'b1; cfgTwosComp = 1'b1; cfgInterp = 2'd0;
    txQual = 1'b0; txData = '0;
    doReset();
    sendSdr(12'h0AB, 1'b0);
    sendSdr(12'h111, 1'b1);
    sendSdr(12'h222, 1'b1);
    sendSdr(12'h333, 1'b0);
    sendSdr(12'h444, 1'b1);
    sendSdr(12'h555, 1'b0);
    @(negedge busClk); txQual = 1'b0; txData = '0;
    expI[0] = 'h222; expQ[0] = 'h333; expI[1] = 'h444; expQ[1] = 'h555; nExp = 2;
    repeat (30) @(negedge busClk);
    chk(nOut == 2, "R4 restart pair count", nOut, 2);
    if (nOut >= 2) compareFrom(0, "R4 restart pair");

    // R8 and R5: slow reader (ratio 8) against back-to-back pairs
    cfgInterp = 2'd3;
    txQual = 1'b0; txData = '0;
    doReset();
    for (int k = 0; k < 20; k++) begin
      expI[k] = (64 + k * 97) % 4096;
      expQ[k] = (3000 + k * 13) % 4096;
      sendSdr(expI[k], 1'b1);
      sendSdr(expQ[k], 1'b0);
    end
    @(negedge busClk); txQual = 1'b0; txData = '0;
    chk(overflowFlag == 1'b1, "R8 overflow set when full", int'(overflowFlag), 1);
    repeat (150) @(negedge busClk);
    chk(overflowFlag == 1'b1, "R8 overflow sticky", int'(overflowFlag), 1);
    chk(nOut >= 8 && nOut < 20, "R8 some pairs dropped", nOut, 14);
    nExp = 8;
    if (nOut >= 8) compareFrom(0, "R8 oldest pairs kept in order");
    if (nOut >= 5)
      chk((outT[4] - outT[3]) > 31.9 && (outT[4] - outT[3]) < 32.1,
          "R5 slot spacing ratio 8 (ns)", int'(outT[4] - outT[3]), 32);
    chk(underflowFlag == 1'b1, "R9 underflow after drain slow", int'(underflowFlag), 1);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule